// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block sits on the device side of an 8-bit multiplexed NAND flash port. It watches the shared byte bus and takes a byte on each rising edge of the active-low write strobe while chip enable is low. The command-latch input marks the byte as a command and the address-latch input marks it as an address. Commands are decoded into read, program, erase, status, identification and reset actions. Address bytes are assembled into a column byte and a 17-bit page (row) address.

A page read starts a busy period after its fourth address byte. A page program needs a setup code, four address bytes and a confirm code. A block erase needs a setup code, three row bytes and a confirm code. The length of each busy period comes from a parameterised cycle count, one per operation type. The block also applies the write-protect and chip-enable rules, and it filters the commands that arrive while it is busy. Read data, the array and analog timing are handled by other blocks. Those blocks use the `launch` pulse, `launch_kind`, the address outputs, `area` and `out_sel`.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is taken only on a rising edge of `we_n` while `ce_n` is low. It is a command when `cle` is high and `ale` is low. It is an address when `ale` is high and `cle` is low. Every other combination is ignored.
- R2: In idle, 70h sets `out_sel` to 2 (status) and 90h sets it to 3 (identification). Any other code leaves `out_sel` at 0, and unlisted codes have no effect.
- R3: Address bytes fill the outputs as follows. Byte 1 goes to `col_addr`. Byte 2 goes to `row_addr[7:0]` and byte 3 to `row_addr[15:8]`. Bit 0 of byte 4 goes to `row_addr[16]`, and bits 7:1 of byte 4 are dropped.
- R4: A read setup code selects `area`: 00h gives 0 (first half), 01h gives 1 (second half, column bit 8 set), and 50h gives 2 (spare).
- R5: The fourth address byte after a read setup code produces one `launch` pulse with `launch_kind` 0. `ready` is then low for exactly T_READ cycles, and afterwards `out_sel` is 1.
- R6: 80h, four address bytes and 10h produce a launch with `launch_kind` 1. `ready` is then low for exactly T_PROG cycles.
- R7: 60h, three address bytes and D0h produce a launch with `launch_kind` 2. The three bytes load `row_addr` in the byte 2 to byte 4 layout, and `col_addr` is unchanged. `ready` is then low for exactly T_ERASE cycles.
- R8: If `wp_n` is low when 10h or D0h is taken, no program or erase is launched and the sequence returns to idle.
- R9: While busy, 70h sets `out_sel` to 2 and FFh ends the busy period early. Every other command is ignored and leaves no pending sequence.
- R10: When `ce_n` is high and the block is not busy, the block goes to standby: `out_sel` returns to 0 and any partial sequence is dropped. While busy, `ce_n` high does not shorten the busy period.
- R11: A confirm code with no matching setup code, or with the wrong number of address bytes before it, returns the sequence to idle with no launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command-latch select |
| ale | input | 1 | Address-latch select |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Shared command/address byte |
| ready | output | 1 | High when idle, low while an operation runs |
| launch | output | 1 | One-cycle pulse when an operation starts |
| launch_kind | output | 2 | 0 read, 1 program, 2 erase |
| col_addr | output | 8 | Assembled column byte |
| row_addr | output | 17 | Assembled page address |
| area | output | 2 | Read area: 0 first half, 1 second half, 2 spare |
| out_sel | output | 2 | Output source: 0 none, 1 page data, 2 status, 3 identification |

## Verification
The assertions are checked on every cycle and cover four properties: a strobe never appears without chip enable and the right latch input, `ready` drops after every launch, the timer is never restarted while it runs, and a busy period is not cut short except by reset. They also check that write protect blocks every confirm and that commands filtered during busy leave the sequencer state and output selection unchanged. The bench scenarios show the rest. These are the exact busy lengths, the address byte layout, the area and output-selection results of each command code, the dropping of partial sequences by chip enable, and the rejection of confirm codes that arrive with the wrong number of address bytes.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_PROG  = 2'd1,
    KIND_ERASE = 2'd2
  } op_kind_t;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_PAGE   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_ID     = 2'd3
  } out_sel_t;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_RD_ADDR = 3'd1,
    SQ_PG_ADDR = 3'd2,
    SQ_PG_DATA = 3'd3,
    SQ_ER_ADDR = 3'd4,
    SQ_ER_WAIT = 3'd5
  } seq_t;

  typedef enum logic [3:0] {
    C_NONE, C_READ_A, C_READ_B, C_READ_SP, C_ID, C_RESET,
    C_PROG, C_PROG_GO, C_ERASE, C_ERASE_GO, C_STATUS
  } cmd_t;

  // Full-address and row-only byte counts
  localparam int FULL_CYC = 4;
  localparam int ROW_CYC  = 3;

  function automatic cmd_t decode_cmd(input logic [7:0] b);
    case (b)
      8'h00:   return C_READ_A;
      8'h01:   return C_READ_B;
      8'h50:   return C_READ_SP;
      8'h90:   return C_ID;
      8'hFF:   return C_RESET;
      8'h80:   return C_PROG;
      8'h10:   return C_PROG_GO;
      8'h60:   return C_ERASE;
      8'hD0:   return C_ERASE_GO;
      8'h70:   return C_STATUS;
      default: return C_NONE;
    endcase
  endfunction

endpackage

// File: rtl/nand_bus_capture.sv
module nand_bus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_n,
  input  logic [DATA_W-1:0] io_in,
  output logic              cmd_stb,
  output logic              addr_stb,
  output logic [DATA_W-1:0] byte_q
);

  logic we_q;
  logic rise;

  assign rise = we_n && !we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q     <= 1'b1;
      cmd_stb  <= 1'b0;
      addr_stb <= 1'b0;
      byte_q   <= '0;
    end else begin
      we_q     <= we_n;
      cmd_stb  <= rise && !ce_n && cle && !ale;
      addr_stb <= rise && !ce_n && ale && !cle;
      if (rise && !ce_n && (cle ^ ale)) byte_q <= io_in;
    end
  end

  // R1: a strobe only follows an enabled strobe edge with the right select
  a_r1_cmd_qualified: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> $past(!ce_n && we_n && cle && !ale));
  a_r1_addr_qualified: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> $past(!ce_n && we_n && ale && !cle));

endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm #(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              row_only,
  input  logic              addr_stb,
  input  logic [DATA_W-1:0] byte_in,
  output logic [DATA_W-1:0] col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [2:0]        cnt_o
);

  localparam int LANES = (ROW_W - 1) / DATA_W;
  localparam int HI_W  = ROW_W - LANES * DATA_W;

  logic [2:0] cnt_q;
  logic [3:0] slot;

  // Row-only sequences start at the first row lane
  assign slot  = {1'b0, cnt_q} + {3'b000, row_only};
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (addr_stb && cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) col_o <= '0;
    else if (addr_stb && slot == 4'd0) col_o <= byte_in;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (addr_stb && slot == 4'(g + 1)) q <= byte_in;
    end
    assign row_o[g*DATA_W +: DATA_W] = q;
  end

  logic [HI_W-1:0] hi_q;
  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else if (addr_stb && slot == 4'(LANES + 1)) hi_q <= byte_in[HI_W-1:0];
  end
  assign row_o[ROW_W-1 -: HI_W] = hi_q;

  // R3: the column byte is only written by the first byte of a full sequence
  a_r3_col_first_only: assert property (@(posedge clk) disable iff (rst)
    (addr_stb && (cnt_q != 3'd0 || row_only)) |=> $stable(col_o));

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int T_READ  = 500,
  parameter int T_PROG  = 10000,
  parameter int T_ERASE = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] kind,
  input  logic       abort,
  output logic       busy
);

  import nand_fe_pkg::*;

  localparam int T_MAX = (T_ERASE > T_PROG) ? ((T_ERASE > T_READ) ? T_ERASE : T_READ)
                                            : ((T_PROG > T_READ) ? T_PROG : T_READ);
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;

  always_comb begin
    case (kind)
      KIND_PROG:  load = CNT_W'(T_PROG - 1);
      KIND_ERASE: load = CNT_W'(T_ERASE - 1);
      default:    load = CNT_W'(T_READ - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= load;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9: an operation is never started on top of a running one
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
  // R10: only reset or count exhaustion ends a busy period
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != '0 && !abort) |=> busy);

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
  parameter int DATA_W  = 8,
  parameter int ROW_W   = 17,
  parameter int T_READ  = 500,
  parameter int T_PROG  = 10000,
  parameter int T_ERASE = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_n,
  input  logic              wp_n,
  input  logic [DATA_W-1:0] io_in,
  output logic              ready,
  output logic              launch,
  output logic [1:0]        launch_kind,
  output logic [DATA_W-1:0] col_addr,
  output logic [ROW_W-1:0]  row_addr,
  output logic [1:0]        area,
  output logic [1:0]        out_sel
);

  import nand_fe_pkg::*;

  logic              cmd_stb;
  logic              addr_stb;
  logic [DATA_W-1:0] bus_q;
  logic [2:0]        acnt;
  logic              busy;
  logic              abort;
  logic              row_only;
  cmd_t              cmd;
  seq_t              state;
  logic [1:0]        sel_q;
  logic [1:0]        area_q;
  logic [1:0]        kind_q;
  logic              launch_q;

  nand_bus_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .io_in(io_in), .cmd_stb(cmd_stb), .addr_stb(addr_stb), .byte_q(bus_q)
  );

  assign row_only = (state == SQ_ER_ADDR);

  nand_addr_asm #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_asm (
    .clk(clk), .rst(rst), .clear(cmd_stb), .row_only(row_only),
    .addr_stb(addr_stb), .byte_in(bus_q),
    .col_o(col_addr), .row_o(row_addr), .cnt_o(acnt)
  );

  assign cmd   = decode_cmd(bus_q[7:0]);
  assign abort = busy && cmd_stb && (cmd == C_RESET);

  nand_busy_timer #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) u_tmr (
    .clk(clk), .rst(rst), .start(launch_q), .kind(kind_q), .abort(abort), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      sel_q    <= SEL_NONE;
      area_q   <= 2'd0;
      kind_q   <= KIND_READ;
      launch_q <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      if (busy) begin
        if (cmd_stb && cmd == C_STATUS) sel_q <= SEL_STATUS;
        if (cmd_stb && cmd == C_RESET) begin
          sel_q <= SEL_NONE;
          state <= SQ_IDLE;
        end
      end else if (ce_n) begin
        state <= SQ_IDLE;
        sel_q <= SEL_NONE;
      end else if (cmd_stb) begin
        case (cmd)
          C_READ_A, C_READ_B, C_READ_SP: begin
            state  <= SQ_RD_ADDR;
            sel_q  <= SEL_NONE;
            area_q <= (cmd == C_READ_A) ? 2'd0 : (cmd == C_READ_B) ? 2'd1 : 2'd2;
          end
          C_PROG: begin
            state <= SQ_PG_ADDR;
            sel_q <= SEL_NONE;
          end
          C_ERASE: begin
            state <= SQ_ER_ADDR;
            sel_q <= SEL_NONE;
          end
          C_STATUS: begin
            state <= SQ_IDLE;
            sel_q <= SEL_STATUS;
          end
          C_ID: begin
            state <= SQ_IDLE;
            sel_q <= SEL_ID;
          end
          C_RESET: begin
            state <= SQ_IDLE;
            sel_q <= SEL_NONE;
          end
          C_PROG_GO: begin
            state <= SQ_IDLE;
            if (state == SQ_PG_DATA && wp_n) begin
              launch_q <= 1'b1;
              kind_q   <= KIND_PROG;
            end
          end
          C_ERASE_GO: begin
            state <= SQ_IDLE;
            if (state == SQ_ER_WAIT && wp_n) begin
              launch_q <= 1'b1;
              kind_q   <= KIND_ERASE;
            end
          end
          default: ;
        endcase
      end else if (addr_stb) begin
        case (state)
          SQ_RD_ADDR: if (acnt == 3'(FULL_CYC - 1)) begin
            state    <= SQ_IDLE;
            sel_q    <= SEL_PAGE;
            launch_q <= 1'b1;
            kind_q   <= KIND_READ;
          end
          SQ_PG_ADDR: if (acnt == 3'(FULL_CYC - 1)) state <= SQ_PG_DATA;
          SQ_ER_ADDR: if (acnt == 3'(ROW_CYC - 1))  state <= SQ_ER_WAIT;
          SQ_PG_DATA, SQ_ER_WAIT: state <= SQ_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign ready       = !busy;
  assign launch      = launch_q;
  assign launch_kind = kind_q;
  assign area        = area_q;
  assign out_sel     = sel_q;

  // R5: every launch is followed by a busy period
  a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
    launch_q |=> !ready);
  // R8: a confirm taken with write protect low never launches
  a_r8_wp_inhibit: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && !wp_n) |=> !launch_q);
  // R9: filtered commands during busy leave sequencer and selection unchanged
  a_r9_busy_filter: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_stb && cmd != C_STATUS && cmd != C_RESET) |=>
      (state == $past(state) && sel_q == $past(sel_q)));

endmodule

// File: tb/nand_cmd_front_bench.sv
`timescale 1ns/1ps
module nand_cmd_front_bench;

  localparam int TR = 6;
  localparam int TP = 20;
  localparam int TE = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, wp_n = 1'b1;
  logic [7:0]  io_in = 8'h00;
  logic        ready, launch;
  logic [1:0]  launch_kind, area, out_sel;
  logic [7:0]  col_addr;
  logic [16:0] row_addr;

  int nchk = 0, nfail = 0;
  int totlow = 0, totlaunch = 0;
  logic [1:0] lastkind = 2'd3;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_cmd_front #(.DATA_W(8), .ROW_W(17), .T_READ(TR), .T_PROG(TP), .T_ERASE(TE)) u_nand_cmd_front (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .wp_n(wp_n),
    .io_in(io_in), .ready(ready), .launch(launch), .launch_kind(launch_kind),
    .col_addr(col_addr), .row_addr(row_addr), .area(area), .out_sel(out_sel)
  );

  always @(negedge clk) begin
    if (!rst && !ready) totlow++;
    if (!rst && launch) begin
      totlaunch++;
      lastkind = launch_kind;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] d, input logic ce);
    @(negedge clk);
    ce_n = ce; cle = c; ale = a; io_in = d; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);  bus_wr(1'b1, 1'b0, d, 1'b0); endtask
  task automatic adr(input logic [7:0] d);  bus_wr(1'b0, 1'b1, d, 1'b0); endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    for (int k = 0; k < 400 && !ready; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=expired expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    int bl, bn;
    logic [7:0] c1, b1, b2, b3, c;
    logic [16:0] er;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    ce_n = 1'b0;
    @(negedge clk);
    chk("reset ready", ready, 1);
    chk("reset out_sel", out_sel, 0);
    chk("reset launch", launch, 0);

    // R2 / R11: sweep of every code from idle
    for (int i = 0; i < 256; i++) begin
      c = 8'(i);
      bl = totlow; bn = totlaunch;
      cmd(c);
      settle();
      chk($sformatf("R2 out_sel code %0h", c), out_sel,
          (c == 8'h70) ? 2 : (c == 8'h90) ? 3 : 0);
      chk($sformatf("R11 no launch code %0h", c), totlaunch - bn, 0);
      chk($sformatf("R11 no busy code %0h", c), totlow - bl, 0);
      cmd(8'hFF);
    end

    // R3 R4 R5: page reads, every area, several address patterns
    for (int a = 0; a < 3; a++) begin
      for (int i = 0; i < 6; i++) begin
        c  = (a == 0) ? 8'h00 : (a == 1) ? 8'h01 : 8'h50;
        c1 = 8'(i * 53 + 7); b1 = 8'(i * 29 + 1); b2 = ~8'(i * 17); b3 = 8'hA0 | 8'(i + a);
        bl = totlow; bn = totlaunch;
        cmd(c); adr(c1); adr(b1); adr(b2); adr(b3);
        settle();
        chk("R3 col", col_addr, c1);
        chk("R3 row", row_addr, {b3[0], b2, b1});
        chk("R4 area", area, a);
        chk("R5 kind", lastkind, 0);
        chk("R5 launches", totlaunch - bn, 1);
        chk("R5 busy cycles", totlow - bl, TR);
        chk("R5 out_sel page", out_sel, 1);
      end
    end

    // R6: program
    for (int i = 0; i < 4; i++) begin
      bl = totlow; bn = totlaunch;
      cmd(8'h80); adr(8'(i + 3)); adr(8'(i * 7)); adr(8'h3C ^ 8'(i)); adr(8'(i));
      adr(8'h55); // stray address in data phase counts as too many -> R11
      cmd(8'h10);
      settle();
      chk("R11 extra address drops program", totlaunch - bn, 0);
      bl = totlow; bn = totlaunch;
      cmd(8'h80); adr(8'(i + 3)); adr(8'(i * 7)); adr(8'h3C ^ 8'(i)); adr(8'(i));
      cmd(8'h10);
      settle();
      chk("R6 kind", lastkind, 1);
      chk("R6 launches", totlaunch - bn, 1);
      chk("R6 busy cycles", totlow - bl, TP);
      chk("R6 row", row_addr, {i[0], 8'h3C ^ 8'(i), 8'(i * 7)});
    end

    // R7: erase keeps the column, fills the row lanes
    c1 = col_addr;
    er = 17'h1_5A3C;
    bl = totlow; bn = totlaunch;
    cmd(8'h60); adr(er[7:0]); adr(er[15:8]); adr({7'h7F, er[16]});
    cmd(8'hD0);
    settle();
    chk("R7 kind", lastkind, 2);
    chk("R7 launches", totlaunch - bn, 1);
    chk("R7 busy cycles", totlow - bl, TE);
    chk("R7 row", row_addr, er);
    chk("R7 col kept", col_addr, c1);

    // R8: write protect
    wp_n = 1'b0;
    bn = totlaunch; bl = totlow;
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h00); cmd(8'h10);
    settle();
    chk("R8 program blocked", totlaunch - bn, 0);
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h00); cmd(8'hD0);
    settle();
    chk("R8 erase blocked", totlaunch - bn, 0);
    chk("R8 no busy", totlow - bl, 0);
    wp_n = 1'b1;
    cmd(8'hD0); // R8: sequence returned to idle, confirm alone does nothing
    settle();
    chk("R8 idle after block", totlaunch - bn, 0);

    // R11: wrong address counts
    bn = totlaunch;
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h10);
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); cmd(8'hD0);
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h10);
    settle();
    chk("R11 miscounted confirms", totlaunch - bn, 0);

    // R1: both selects high, or chip enable high, are ignored
    bn = totlaunch;
    bus_wr(1'b1, 1'b1, 8'h80, 1'b0);
    adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h00); cmd(8'h10);
    settle();
    chk("R1 both selects ignored", totlaunch - bn, 0);
    bus_wr(1'b1, 1'b0, 8'h90, 1'b1);
    ce_n = 1'b0;
    settle();
    chk("R1 ce high ignored", out_sel, 0);
    bus_wr(1'b0, 1'b0, 8'h90, 1'b0);
    settle();
    chk("R1 data cycle ignored", out_sel, 0);

    // R9: commands during busy
    bl = totlow; bn = totlaunch;
    cmd(8'h60); adr(8'h10); adr(8'h20); adr(8'h00); cmd(8'hD0);
    cmd(8'h70);
    repeat (2) @(negedge clk);
    chk("R9 still busy", ready, 0);
    chk("R9 status during busy", out_sel, 2);
    cmd(8'h00);
    cmd(8'h90);
    settle();
    chk("R9 busy full length", totlow - bl, TE);
    chk("R9 status kept", out_sel, 2);
    adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04);
    settle();
    chk("R9 read ignored while busy", totlaunch - bn, 1);
    bl = totlow;
    cmd(8'h60); adr(8'h10); adr(8'h20); adr(8'h00); cmd(8'hD0);
    repeat (3) @(negedge clk);
    cmd(8'hFF);
    repeat (3) @(negedge clk);
    chk("R9 reset ends busy", ready, 1);
    chk("R9 reset shortened", (totlow - bl) < TE, 1);

    // R10: standby and busy immunity
    cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'h00); adr(8'h00);
    settle();
    chk("R10 page before standby", out_sel, 1);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 standby clears out_sel", out_sel, 0);
    ce_n = 1'b0;
    bn = totlaunch;
    cmd(8'h80); adr(8'h01); adr(8'h02);
    ce_n = 1'b1; repeat (3) @(negedge clk); ce_n = 1'b0;
    adr(8'h03); adr(8'h00); cmd(8'h10);
    settle();
    chk("R10 partial sequence dropped", totlaunch - bn, 0);
    bl = totlow;
    cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h00); cmd(8'h10);
    ce_n = 1'b1;
    settle();
    ce_n = 1'b0;
    chk("R10 busy ignores ce", totlow - bl, TP);

    done = 1;
    report();
    $finish;
  end

endmodule